// File: doc/BRIEF.md
# Two-Channel Virtual Channel Link Multiplexer

This block lets two virtual channels, A and B, share one physical output link. Each channel presents a stream of packets made of flits. A packet opens with a head flit and continues with its data flits in order, and the final flit carries a last marker. A channel may stall part way through a packet. When that happens, the shared link can still carry traffic from the other channel, so one blocked packet does not hold up the link.

A mode input chooses the scheduling policy. In interleaved mode (`modeWta` = 0) the link carries one flit from each channel in turn. In whole-packet mode (`modeWta` = 1) a channel that has started a packet keeps the link until its last flit has gone. Each output flit carries a one-bit channel tag, so the receiver can split the two streams apart again. The inputs use a valid/ready handshake. The output sits in a single register stage that obeys downstream backpressure.

Top module: `vcmux_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0. With no input valid, `aReady` and `bReady` are 0.
- R2: In interleaved mode, when both channels keep a flit valid, the output alternates between channels one flit at a time. With packets A and B offered together after reset the order is A0, B0, A1, B1, A2, B2.
- R3: In interleaved mode, a channel that is the only one with a valid flit is served on every cycle with no idle slot. If the other channel stalls in the middle of a packet, this channel's flits pass it.
- R4: In whole-packet mode, when both channels offer a packet, every flit of one packet (head through last) is sent before any flit of the other packet.
- R5: In whole-packet mode, once a channel's head flit is accepted and it is not a last flit, the other channel gets no ready until that channel's last flit is accepted. This holds even when the owning channel stalls mid-packet.
- R6: When both channels become valid together with no packet in progress, the channel that was not served most recently wins. After reset, channel A counts as not served most recently.
- R7: While `outValid` is 1 and `outReady` is 0, `outData`, `outVc` and `outLast` hold their values and `outValid` stays 1.
- R8: An accepted flit appears on the output on the clock edge after its acceptance. `outVc` is 0 for a channel A flit and 1 for a channel B flit, and `outData` and `outLast` are copied unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWta | input | 1 | 0 = flit interleave, 1 = whole packet |
| aValid | input | 1 | Channel A flit valid |
| aReady | output | 1 | Channel A flit accepted this cycle |
| aData | input | DATA_W | Channel A flit payload |
| aLast | input | 1 | Channel A flit ends its packet |
| bValid | input | 1 | Channel B flit valid |
| bReady | output | 1 | Channel B flit accepted this cycle |
| bData | input | DATA_W | Channel B flit payload |
| bLast | input | 1 | Channel B flit ends its packet |
| outValid | output | 1 | Output flit valid |
| outReady | input | 1 | Downstream accepts the output flit |
| outData | output | DATA_W | Output flit payload |
| outLast | output | 1 | Output flit ends its packet |
| outVc | output | 1 | Source channel tag (0 = A, 1 = B) |

## Verification
An input flit that is accepted at one rising edge shows up on the output after that same edge. It is consumed downstream at the next rising edge on which `outReady` is high, so the output order and cycle stamps can be rebuilt exactly from the handshakes. The sources decide whether a flit fires by reading the ready signal one nanosecond after the falling edge. A monitor logs every output flit that will be consumed at that same point. The checks then compare this log with the sequence that each policy prescribes, and they also compare cycle stamps to detect idle slots. Stall stability is sampled on each falling edge while `outReady` is held low.

// File: rtl/vcmux_pkg.sv
package vcmux_pkg;
  localparam logic VC_A = 1'b0;
  localparam logic VC_B = 1'b1;

  typedef struct packed {
    logic loadEn;
    logic push;
    logic selB;
  } strobe_t;
endpackage

// File: rtl/vcmux_ctrl.sv
module vcmux_ctrl
  import vcmux_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeWta,
  input  logic    aValid,
  input  logic    aLast,
  input  logic    bValid,
  input  logic    bLast,
  input  logic    outValid,
  input  logic    outReady,
  output logic    aReady,
  output logic    bReady,
  output strobe_t strobe
);
  logic lastServedB;
  logic locked;
  logic lockOwner;
  logic canLoad;
  logic pickA;
  logic pickB;
  logic fire;
  logic firedLast;

  always_comb begin
    canLoad = !outValid || outReady;
    if (modeWta && locked) begin
      pickA = (lockOwner == VC_A) && aValid;
      pickB = (lockOwner == VC_B) && bValid;
    end else if (aValid && bValid) begin
      pickA = lastServedB;
      pickB = !lastServedB;
    end else begin
      pickA = aValid;
      pickB = bValid;
    end
    aReady        = canLoad && pickA;
    bReady        = canLoad && pickB;
    fire          = aReady || bReady;
    firedLast     = bReady ? bLast : aLast;
    strobe.loadEn = canLoad;
    strobe.push   = fire;
    strobe.selB   = pickB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastServedB <= VC_B;
      locked      <= 1'b0;
      lockOwner   <= VC_A;
    end else begin
      if (fire) begin
        lastServedB <= bReady;
        lockOwner   <= bReady ? VC_B : VC_A;
      end
      if (!modeWta) begin
        locked <= 1'b0;
      end else if (fire) begin
        locked <= !firedLast;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aReady, bReady})); // R4
  AST_WTA_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    modeWta && aValid && aReady && !aLast |=> !modeWta || !bReady); // R5
  AST_WTA_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    modeWta && bValid && bReady && !bLast |=> !modeWta || !aReady); // R5
  AST_ILV_TURN_A: assert property (@(posedge clk) disable iff (!rstN)
    !modeWta && aReady && bValid |=> modeWta || !aReady); // R2
  AST_ILV_TURN_B: assert property (@(posedge clk) disable iff (!rstN)
    !modeWta && bReady && aValid |=> modeWta || !bReady); // R2
endmodule

// File: rtl/vcmux_datapath.sv
module vcmux_datapath
  import vcmux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] aData,
  input  logic              aLast,
  input  logic [DATA_W-1:0] bData,
  input  logic              bLast,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outVc
);
  logic [DATA_W-1:0] muxData;
  logic              muxLast;

  always_comb begin
    muxData = strobe.selB ? bData : aData;
    muxLast = strobe.selB ? bLast : aLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
      outVc    <= VC_A;
    end else if (strobe.loadEn) begin
      outValid <= strobe.push;
      if (strobe.push) begin
        outData <= muxData;
        outLast <= muxLast;
        outVc   <= strobe.selB ? VC_B : VC_A;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !outValid); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outVc) && $stable(outLast)); // R7
  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> outValid && (outVc == $past(strobe.selB))); // R8
endmodule

// File: rtl/vcmux_link.sv
module vcmux_link
  import vcmux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWta,
  input  logic              aValid,
  output logic              aReady,
  input  logic [DATA_W-1:0] aData,
  input  logic              aLast,
  input  logic              bValid,
  output logic              bReady,
  input  logic [DATA_W-1:0] bData,
  input  logic              bLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outVc
);
  strobe_t strobe;

  vcmux_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeWta  (modeWta),
    .aValid   (aValid),
    .aLast    (aLast),
    .bValid   (bValid),
    .bLast    (bLast),
    .outValid (outValid),
    .outReady (outReady),
    .aReady   (aReady),
    .bReady   (bReady),
    .strobe   (strobe)
  );

  vcmux_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .aData    (aData),
    .aLast    (aLast),
    .bData    (bData),
    .bLast    (bLast),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast),
    .outVc    (outVc)
  );
endmodule

// File: tb/sim_vcmux_link.sv
`timescale 1ns/1ps
module sim_vcmux_link;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWta = 1'b0;
  logic outReady = 1'b1;
  logic [1:0] srcValid = 2'b00;
  logic [7:0] srcD [2];
  logic [1:0] srcL = 2'b00;
  logic aReady, bReady, outValid, outLast, outVc;
  logic [7:0] outData;

  logic [7:0] srcData [2][32];
  logic       srcLast [2][32];
  int         srcGap  [2][32];
  int         srcN    [2];
  logic [1:0] srcGo = 2'b00;

  logic [7:0] logD [64];
  logic       logVc [64];
  logic       logL [64];
  int         logCyc [64];
  int         logN = 0;
  int         cycleCnt = 0;

  logic [7:0] expD [64];
  logic       expL [64];
  int         expN = 0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  vcmux_link #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .modeWta(modeWta),
    .aValid(srcValid[0]), .aReady(aReady), .aData(srcD[0]), .aLast(srcL[0]),
    .bValid(srcValid[1]), .bReady(bReady), .bData(srcD[1]), .bLast(srcL[1]),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outVc(outVc)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic driveSrc(input int ch);
    forever begin
      wait (srcGo[ch]);
      for (int i = 0; i < srcN[ch]; i++) begin
        for (int g = 0; g < srcGap[ch][i]; g++) begin
          @(negedge clk);
          srcValid[ch] = 1'b0;
        end
        @(negedge clk);
        srcValid[ch] = 1'b1;
        srcD[ch] = srcData[ch][i];
        srcL[ch] = srcLast[ch][i];
        #1;
        while (!(ch == 0 ? aReady : bReady)) begin
          @(negedge clk);
          #1;
        end
      end
      @(negedge clk);
      srcValid[ch] = 1'b0;
      srcGo[ch] = 1'b0;
    end
  endtask

  initial driveSrc(0);
  initial driveSrc(1);

  initial forever begin
    @(negedge clk);
    #1;
    if (rstN && outValid && outReady && logN < 64) begin
      logD[logN] = outData;
      logVc[logN] = outVc;
      logL[logN] = outLast;
      logCyc[logN] = cycleCnt;
      logN++;
    end
  end

  // Flit payload: high nibble A or B names the channel, low nibble the flit index.
  task automatic loadPkt(input int ch, input int first, input int len, input int gapAt, input int gapLen);
    for (int i = 0; i < len; i++) begin
      srcData[ch][srcN[ch]] = {(ch == 0) ? 4'hA : 4'hB, 4'(first + i)};
      srcLast[ch][srcN[ch]] = (i == len - 1);
      srcGap[ch][srcN[ch]]  = (i == gapAt) ? gapLen : 0;
      srcN[ch]++;
    end
  endtask

  task automatic expect1(input int ch, input int idx, input logic last);
    expD[expN] = {(ch == 0) ? 4'hA : 4'hB, 4'(idx)};
    expL[expN] = last;
    expN++;
  endtask

  task automatic applyReset(input logic wta);
    @(negedge clk);
    rstN = 1'b0;
    modeWta = wta;
    outReady = 1'b1;
    srcValid = 2'b00;
    srcN[0] = 0;
    srcN[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    logN = 0;
    expN = 0;
  endtask

  task automatic waitLog(input int n);
    for (int t = 0; t < 200 && logN < n; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic checkLog(input string tag);
    chk(logN == expN, {tag, " flit count"}, logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logD[i] == expD[i], {tag, " order/data"}, logD[i], expD[i]);
      chk(logVc[i] == (expD[i][7:4] == 4'hB), {tag, " R8 vc tag"}, logVc[i], expD[i][7:4] == 4'hB);
      chk(logL[i] == expL[i], {tag, " R8 last"}, logL[i], expL[i]);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    srcValid = 2'b00;
    @(negedge clk);
    #1;
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk({aReady, bReady} == 2'b00, "R1 readies idle", {aReady, bReady}, 0);
  endtask

  task automatic testInterleave();
    applyReset(1'b0);
    loadPkt(0, 0, 3, -1, 0);
    loadPkt(1, 0, 3, -1, 0);
    for (int i = 0; i < 3; i++) begin
      expect1(0, i, i == 2);
      expect1(1, i, i == 2);
    end
    srcGo = 2'b11;
    waitLog(6);
    checkLog("R2 R6 interleave");
  endtask

  task automatic testSingleAndBypass();
    applyReset(1'b0);
    loadPkt(0, 0, 4, -1, 0);
    for (int i = 0; i < 4; i++) expect1(0, i, i == 3);
    srcGo = 2'b01;
    waitLog(4);
    checkLog("R3 single channel");
    for (int i = 1; i < 4 && i < logN; i++)
      chk(logCyc[i] == logCyc[0] + i, "R3 no idle slot", logCyc[i] - logCyc[0], i);
    applyReset(1'b0);
    loadPkt(0, 0, 3, 1, 3);
    loadPkt(1, 0, 3, -1, 0);
    expect1(0, 0, 0); expect1(1, 0, 0); expect1(1, 1, 0);
    expect1(1, 2, 1); expect1(0, 1, 0); expect1(0, 2, 1);
    srcGo = 2'b11;
    waitLog(6);
    checkLog("R3 bypass stalled A");
  endtask

  task automatic testWta();
    applyReset(1'b1);
    loadPkt(0, 0, 3, -1, 0);
    loadPkt(1, 0, 3, -1, 0);
    for (int i = 0; i < 3; i++) expect1(0, i, i == 2);
    for (int i = 0; i < 3; i++) expect1(1, i, i == 2);
    srcGo = 2'b11;
    waitLog(6);
    checkLog("R4 whole packet");
    applyReset(1'b1);
    loadPkt(0, 0, 3, 1, 3);
    loadPkt(1, 0, 3, -1, 0);
    for (int i = 0; i < 3; i++) expect1(0, i, i == 2);
    for (int i = 0; i < 3; i++) expect1(1, i, i == 2);
    srcGo = 2'b11;
    waitLog(6);
    checkLog("R5 lock through stall");
  endtask

  task automatic testTie();
    applyReset(1'b1);
    loadPkt(0, 0, 2, -1, 0);
    expect1(0, 0, 0); expect1(0, 1, 1);
    srcGo = 2'b01;
    waitLog(2);
    srcN[0] = 0;
    srcN[1] = 0;
    loadPkt(0, 2, 2, -1, 0);
    loadPkt(1, 0, 2, -1, 0);
    expect1(1, 0, 0); expect1(1, 1, 1); expect1(0, 2, 0); expect1(0, 3, 1);
    srcGo = 2'b11;
    waitLog(6);
    checkLog("R6 tie to less recent");
  endtask

  task automatic testBackpressure();
    logic [7:0] d0;
    logic v0;
    logic l0;
    applyReset(1'b0);
    outReady = 1'b0;
    loadPkt(0, 0, 2, -1, 0);
    loadPkt(1, 0, 2, -1, 0);
    expect1(0, 0, 0); expect1(1, 0, 0); expect1(0, 1, 1); expect1(1, 1, 1);
    srcGo = 2'b11;
    repeat (2) @(negedge clk);
    #1;
    d0 = outData; v0 = outVc; l0 = outLast;
    chk(outValid == 1'b1 && d0 == 8'hA0, "R7 first flit held", d0, 8'hA0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      chk(outValid && outData == d0 && outVc == v0 && outLast == l0,
          "R7 stable under stall", outData, d0);
    end
    @(negedge clk);
    outReady = 1'b1;
    waitLog(4);
    checkLog("R7 order after stall");
  endtask

  initial begin
    srcN[0] = 0;
    srcN[1] = 0;
    testReset();
    testInterleave();
    testSingleAndBypass();
    testWta();
    testTie();
    testBackpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycleCnt);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule